// File: doc/BRIEF.md
# Seconds Counter Real-Time Clock with Alarm

This peripheral keeps time as a raw count of seconds in a single register. A prescaler divides the block clock by a parameter to make a one-second update strobe. While counting is enabled, every strobe adds one to the count. Software can stage a new count, which takes effect at the next update. It can also program an alarm value. When the count reaches the alarm value, a level interrupt is raised if alarms are enabled. The interrupt can be masked without losing the pending event, and it is acknowledged by a read with no write needed.

Access is through a small word-addressed register bus. Reads return data one cycle after the strobe. In wrap mode, the count reloads from the staged value when it reaches the alarm value, which gives a repeating period. Without wrap mode the count rolls over at the top of its range.

Top module: `rtc_sec_top`

## Requirements
- R1: After reset, the count, alarm value, staged value and control all read 0, raw and masked status read 0, and `alarm_irq` is low.
- R2: While control bit 2 (count enable) is 1, the count rises by one every `TICK_DIV` clocks. The first update comes `TICK_DIV` clocks after the write that set the bit (prescaler restarts from zero). While the bit is 0, the count and the prescaler hold.
- R3: A write to offset 0x08 (staged value) does not alter the count at once. The count takes that value at the next update, and offset 0x08 reads back the last written value.
- R4: At an update with a staged value still pending, the count takes the staged value instead of incrementing, and instead of a wrap reload.
- R5: With control bit 3 (wrap) at 0, the count goes from 0xFFFFFFFF to 0.
- R6: With wrap at 1, an update taken while the count equals the alarm value (offset 0x04) reloads the count from the staged register.
- R7: At an update whose new count equals the alarm value, raw status (offset 0x14 bit 0) becomes 1 if control bit 0 (alarm enable) is 1, whatever the mask. With alarm enable at 0 it stays 0.
- R8: Masked status (offset 0x10 bit 0) and `alarm_irq` both equal raw status AND NOT control bit 1 (mask). Clearing the mask exposes an event that is already pending.
- R9: A read of offset 0x18 clears raw status and returns 0. Raw status stays clear while the count stays at the alarm value.
- R10: Read data appears on `reg_rdata` the cycle after `reg_rd`. Offset 0x00 gives the count, offset 0x1C gives the `VERSION` parameter, and offset 0x0C gives control in bits 3:0 with the upper bits 0.
- R11: Writes to offsets 0x00, 0x10, 0x14, 0x18, 0x1C and to unmapped addresses have no effect. Unmapped means 0x20 and above, or either low address bit set. Reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, also the prescaler source |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | DATA_W | Write data |
| reg_rd | input | 1 | Read strobe; also triggers the acknowledge read side effect |
| reg_rdata | output | DATA_W | Registered read data |
| alarm_irq | output | 1 | Level alarm interrupt, raw status gated by the mask |

## Verification
The bench builds the block with `TICK_DIV` = 8 and a distinct `VERSION` constant. One simulated second is then eight clocks, so each scenario can run through several updates in a few dozen cycles. Every read is timed to land midway between updates, so the expected count follows directly from the number of updates elapsed. This short period brings alarm hits, wrap reload, rollover from a preloaded 0xFFFFFFFE, and staged-value precedence within a short run.

// File: rtl/rtc_sec_pkg.sv
package rtc_sec_pkg;

  // Word index of each register: byte offset bits [4:2]
  typedef enum logic [2:0] {
    RI_COUNT  = 3'd0,
    RI_ALARM  = 3'd1,
    RI_STAGE  = 3'd2,
    RI_CTRL   = 3'd3,
    RI_MSTAT  = 3'd4,
    RI_RSTAT  = 3'd5,
    RI_ACK    = 3'd6,
    RI_VER    = 3'd7
  } reg_idx_e;

  localparam int unsigned CTRL_W = 4;

  // Control register, bit 3 down to bit 0
  typedef struct packed {
    logic wrap;
    logic cnt_en;
    logic mask;
    logic int_en;
  } ctrl_t;

endpackage

// File: rtl/rtc_sec_prescaler.sv
module rtc_sec_prescaler #(
  parameter int unsigned TICK_DIV = 32768
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);

  localparam int unsigned PW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

  logic [PW-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      phase_q <= '0;
    end else if (phase_q == LAST) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_q + 1'b1;
    end
  end

  assign tick = run && (phase_q == LAST);

endmodule

// File: rtl/rtc_sec_counter.sv
module rtc_sec_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             stage_wr,
  input  logic [CNT_W-1:0] stage_val,
  input  logic [CNT_W-1:0] alarm_val,
  input  logic             wrap_en,
  output logic [CNT_W-1:0] count,
  output logic             stage_pend,
  output logic             hit
);

  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] count_nxt;
  logic             pend_q;
  logic             at_alarm;

  assign at_alarm = (count_q == alarm_val);

  always_comb begin
    if (pend_q) begin
      count_nxt = stage_val;
    end else if (wrap_en && at_alarm) begin
      count_nxt = stage_val;
    end else begin
      count_nxt = count_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      pend_q  <= 1'b0;
    end else begin
      if (tick) begin
        count_q <= count_nxt;
      end
      if (stage_wr) begin
        pend_q <= 1'b1;
      end else if (tick) begin
        pend_q <= 1'b0;
      end
    end
  end

  assign hit        = tick && (count_nxt == alarm_val);
  assign count      = count_q;
  assign stage_pend = pend_q;

endmodule

// File: rtl/rtc_sec_regs.sv
module rtc_sec_regs
  import rtc_sec_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned CNT_W   = 32,
  parameter logic [31:0] VERSION = 32'h0001_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [CNT_W-1:0]  count,
  input  logic              hit,
  output ctrl_t             ctrl,
  output logic [CNT_W-1:0]  alarm_q,
  output logic [CNT_W-1:0]  stage_q,
  output logic              stage_wr,
  output logic              raw_q,
  output logic              masked
);

  localparam int unsigned HI_W = ADDR_W - 5;

  logic     mapped;
  reg_idx_e idx;
  logic     wr_alarm;
  logic     wr_ctrl;
  logic     rd_ack;
  logic [DATA_W-1:0] rd_mux;

  assign mapped   = (bus_addr[ADDR_W-1:5] == HI_W'(0)) && (bus_addr[1:0] == 2'b00);
  assign idx      = reg_idx_e'(bus_addr[4:2]);
  assign wr_alarm = bus_wr && mapped && (idx == RI_ALARM);
  assign stage_wr = bus_wr && mapped && (idx == RI_STAGE);
  assign wr_ctrl  = bus_wr && mapped && (idx == RI_CTRL);
  assign rd_ack   = bus_rd && mapped && (idx == RI_ACK);

  always_ff @(posedge clk) begin
    if (rst) begin
      alarm_q <= '0;
      stage_q <= '0;
      ctrl    <= '0;
    end else begin
      if (wr_alarm) alarm_q <= bus_wdata[CNT_W-1:0];
      if (stage_wr) stage_q <= bus_wdata[CNT_W-1:0];
      if (wr_ctrl)  ctrl    <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
    end
  end

  // Alarm event wins over an acknowledge in the same cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q <= 1'b0;
    end else if (hit && ctrl.int_en) begin
      raw_q <= 1'b1;
    end else if (rd_ack) begin
      raw_q <= 1'b0;
    end
  end

  assign masked = raw_q && !ctrl.mask;

  always_comb begin
    rd_mux = '0;
    if (mapped) begin
      unique case (idx)
        RI_COUNT: rd_mux = DATA_W'(count);
        RI_ALARM: rd_mux = DATA_W'(alarm_q);
        RI_STAGE: rd_mux = DATA_W'(stage_q);
        RI_CTRL:  rd_mux = DATA_W'(ctrl);
        RI_MSTAT: rd_mux = DATA_W'(masked);
        RI_RSTAT: rd_mux = DATA_W'(raw_q);
        RI_ACK:   rd_mux = '0;
        RI_VER:   rd_mux = DATA_W'(VERSION);
        default:  rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      bus_rdata <= rd_mux;
    end
  end

endmodule

// File: rtl/rtc_sec_top.sv
module rtc_sec_top
  import rtc_sec_pkg::*;
#(
  parameter int unsigned TICK_DIV = 32768,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 32,
  parameter logic [31:0] VERSION  = 32'h0001_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_rd,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              alarm_irq
);

  localparam int unsigned CNT_W = DATA_W;

  ctrl_t            ctrl;
  logic             tick;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] alarm_q;
  logic [CNT_W-1:0] stage_q;
  logic             stage_wr;
  logic             stage_pend;
  logic             hit;
  logic             raw_q;
  logic             masked;

  rtc_sec_prescaler #(.TICK_DIV(TICK_DIV)) presc_i (
    .clk  (clk),
    .rst  (rst),
    .run  (ctrl.cnt_en),
    .tick (tick)
  );

  rtc_sec_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .stage_wr   (stage_wr),
    .stage_val  (stage_q),
    .alarm_val  (alarm_q),
    .wrap_en    (ctrl.wrap),
    .count      (count),
    .stage_pend (stage_pend),
    .hit        (hit)
  );

  rtc_sec_regs #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .CNT_W   (CNT_W),
    .VERSION (VERSION)
  ) regs_i (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (reg_addr),
    .bus_wr    (reg_wr),
    .bus_wdata (reg_wdata),
    .bus_rd    (reg_rd),
    .bus_rdata (reg_rdata),
    .count     (count),
    .hit       (hit),
    .ctrl      (ctrl),
    .alarm_q   (alarm_q),
    .stage_q   (stage_q),
    .stage_wr  (stage_wr),
    .raw_q     (raw_q),
    .masked    (masked)
  );

  assign alarm_irq = masked;

endmodule

// File: rtl/rtc_sec_chk.sv
module rtc_sec_chk #(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic              cnt_en,
  input logic [CNT_W-1:0]  count,
  input logic              stage_pend,
  input logic [CNT_W-1:0]  stage_val,
  input logic [CNT_W-1:0]  alarm_val,
  input logic              wrap_en,
  input logic              int_en,
  input logic              mask,
  input logic              raw,
  input logic              irq,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr
);

  logic ack_addr;
  assign ack_addr = (bus_addr == ADDR_W'(8'h18));

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    !cnt_en |=> $stable(count)); // R2

  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (rst)
    (tick && !stage_pend && !(wrap_en && count == alarm_val)) |=> (count == $past(count) + 1'b1)); // R5

  AST_STAGE_FIRST: assert property (@(posedge clk) disable iff (rst)
    (tick && stage_pend) |=> (count == $past(stage_val))); // R4

  AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (rst)
    (tick && !stage_pend && wrap_en && count == alarm_val) |=> (count == $past(stage_val))); // R6

  AST_RAW_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    $rose(raw) |-> $past(int_en)); // R7

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && ack_addr && !tick) |=> !raw); // R9

  AST_MASK_SILENCES: assert property (@(posedge clk) disable iff (rst)
    mask |-> !irq); // R8

  AST_IRQ_NEEDS_RAW: assert property (@(posedge clk) disable iff (rst)
    irq |-> raw); // R8

endmodule

bind rtc_sec_top rtc_sec_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .tick       (tick),
  .cnt_en     (ctrl.cnt_en),
  .count      (count),
  .stage_pend (stage_pend),
  .stage_val  (stage_q),
  .alarm_val  (alarm_q),
  .wrap_en    (ctrl.wrap),
  .int_en     (ctrl.int_en),
  .mask       (ctrl.mask),
  .raw        (raw_q),
  .irq        (alarm_irq),
  .bus_rd     (reg_rd),
  .bus_addr   (reg_addr)
);

// File: tb/rtc_sec_top_tb_top.sv
`timescale 1ns/1ps
module rtc_sec_top_tb_top;

  localparam int unsigned TB_DIV = 8;
  localparam logic [31:0] TB_VER = 32'h5EC0_0102;

  localparam logic [7:0] A_COUNT = 8'h00;
  localparam logic [7:0] A_ALARM = 8'h04;
  localparam logic [7:0] A_STAGE = 8'h08;
  localparam logic [7:0] A_CTRL  = 8'h0C;
  localparam logic [7:0] A_MSTAT = 8'h10;
  localparam logic [7:0] A_RSTAT = 8'h14;
  localparam logic [7:0] A_ACK   = 8'h18;
  localparam logic [7:0] A_VER   = 8'h1C;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic        reg_rd = 1'b0;
  logic [31:0] reg_rdata;
  logic        alarm_irq;

  int n_chk = 0;
  int n_fail = 0;
  int edges = 0;
  logic tb_en = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rtc_sec_top #(
    .TICK_DIV (TB_DIV),
    .ADDR_W   (8),
    .DATA_W   (32),
    .VERSION  (TB_VER)
  ) dut_i (
    .clk       (clk),
    .rst       (rst),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rd    (reg_rd),
    .reg_rdata (reg_rdata),
    .alarm_irq (alarm_irq)
  );

  // Clock edges since counting was last switched on (R2: prescaler restarts)
  always @(posedge clk) begin
    if (rst) begin
      edges <= 0;
      tb_en <= 1'b0;
    end else if (reg_wr && reg_addr == A_CTRL) begin
      tb_en <= reg_wdata[2];
      edges <= (reg_wdata[2] && !tb_en) ? 0 : edges + 1;
    end else begin
      edges <= edges + 1;
    end
  end

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
    logic [31:0] d;
    bus_read(a, d);
    check(tag, d, exp);
  endtask

  task automatic irq_chk(input logic exp, input string tag);
    check(tag, {31'd0, alarm_irq}, {31'd0, exp});
  endtask

  // Park so the next read is captured midway after n updates
  task automatic after_updates(input int n);
    int target;
    target = n * TB_DIV + 3;
    while (edges != target) begin
      if (edges > target) begin
        n_fail++;
        $display("FAIL R2: bench timing overrun, at %0d expected %0d", edges, target);
        return;
      end
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    rd_chk(A_COUNT, 32'd0, "R1 count");
    rd_chk(A_ALARM, 32'd0, "R1 alarm");
    rd_chk(A_STAGE, 32'd0, "R1 stage");
    rd_chk(A_CTRL,  32'd0, "R1 ctrl");
    rd_chk(A_RSTAT, 32'd0, "R1 raw");
    rd_chk(A_MSTAT, 32'd0, "R1 masked");
    irq_chk(1'b0, "R1 irq");
    rd_chk(A_VER, TB_VER, "R10 version");
  endtask

  task automatic t_stage_defer;
    bus_write(A_CTRL, 32'h0);
    bus_write(A_STAGE, 32'd100);
    rd_chk(A_STAGE, 32'd100, "R3 stage readback");
    rd_chk(A_COUNT, 32'd0, "R3 count unchanged before update");
    bus_write(A_CTRL, 32'h4);
    rd_chk(A_COUNT, 32'd0, "R3 count unchanged after enable");
    after_updates(1);
    rd_chk(A_COUNT, 32'd100, "R3 stage applied");
    after_updates(4);
    rd_chk(A_COUNT, 32'd103, "R2 one per period");
  endtask

  task automatic t_hold;
    bus_write(A_CTRL, 32'h0);
    rd_chk(A_COUNT, 32'd103, "R2 halted value");
    repeat (3 * TB_DIV) @(negedge clk);
    rd_chk(A_COUNT, 32'd103, "R2 holds while disabled");
  endtask

  task automatic t_alarm;
    bus_write(A_CTRL, 32'h0);
    bus_write(A_STAGE, 32'd200);
    bus_write(A_ALARM, 32'd202);
    bus_write(A_CTRL, 32'h5);
    after_updates(2);
    rd_chk(A_RSTAT, 32'd0, "R7 no event before alarm");
    irq_chk(1'b0, "R8 irq low before alarm");
    after_updates(3);
    rd_chk(A_RSTAT, 32'd1, "R7 event at alarm");
    rd_chk(A_MSTAT, 32'd1, "R8 masked status");
    irq_chk(1'b1, "R8 irq high");
    rd_chk(A_ACK, 32'd0, "R9 ack reads zero");
    rd_chk(A_RSTAT, 32'd0, "R9 cleared by ack read");
    irq_chk(1'b0, "R9 irq dropped");
    after_updates(4);
    rd_chk(A_COUNT, 32'd203, "R2 counting past alarm");
    rd_chk(A_RSTAT, 32'd0, "R9 stays clear");
  endtask

  task automatic t_mask;
    bus_write(A_CTRL, 32'h0);
    bus_write(A_STAGE, 32'd300);
    bus_write(A_ALARM, 32'd301);
    bus_write(A_CTRL, 32'h7);
    after_updates(2);
    rd_chk(A_RSTAT, 32'd1, "R7 raw set while masked");
    rd_chk(A_MSTAT, 32'd0, "R8 masked status hidden");
    irq_chk(1'b0, "R8 irq held by mask");
    bus_write(A_CTRL, 32'h5);
    rd_chk(A_MSTAT, 32'd1, "R8 unmask exposes event");
    irq_chk(1'b1, "R8 irq after unmask");
    rd_chk(A_ACK, 32'd0, "R9 ack read");
    irq_chk(1'b0, "R9 irq cleared");
  endtask

  task automatic t_wrap;
    bus_write(A_CTRL, 32'h0);
    bus_write(A_STAGE, 32'd400);
    bus_write(A_ALARM, 32'd402);
    bus_write(A_CTRL, 32'hC);
    after_updates(3);
    rd_chk(A_COUNT, 32'd402, "R6 reached alarm");
    rd_chk(A_RSTAT, 32'd0, "R7 no event with alarm disabled");
    after_updates(4);
    rd_chk(A_COUNT, 32'd400, "R6 wrap reload");
    after_updates(5);
    rd_chk(A_COUNT, 32'd401, "R6 counts on after reload");
  endtask

  task automatic t_rollover;
    bus_write(A_CTRL, 32'h0);
    bus_write(A_STAGE, 32'hFFFF_FFFE);
    bus_write(A_CTRL, 32'h4);
    after_updates(2);
    rd_chk(A_COUNT, 32'hFFFF_FFFF, "R5 top value");
    after_updates(3);
    rd_chk(A_COUNT, 32'h0, "R5 rolls to zero");
  endtask

  task automatic t_ignored;
    bus_write(A_CTRL, 32'h0);
    bus_write(A_COUNT, 32'hDEAD_BEEF);
    rd_chk(A_COUNT, 32'h0, "R11 count not writable");
    bus_write(A_VER, 32'h1234_5678);
    rd_chk(A_VER, TB_VER, "R11 version not writable");
    bus_write(A_RSTAT, 32'h1);
    bus_write(A_MSTAT, 32'h1);
    rd_chk(A_RSTAT, 32'h0, "R11 status not writable");
    irq_chk(1'b0, "R11 irq unaffected");
    bus_write(8'h24, 32'h0000_1234);
    bus_write(8'h05, 32'h0000_5678);
    rd_chk(A_ALARM, 32'd402, "R11 unmapped write no alias");
    rd_chk(8'h24, 32'h0, "R11 unmapped read zero");
    bus_write(A_CTRL, 32'hFFFF_FFF0);
    rd_chk(A_CTRL, 32'h0, "R10 control upper bits");
    bus_write(A_CTRL, 32'hFFFF_FFFB);
    rd_chk(A_CTRL, 32'hB, "R10 control low bits");
    bus_write(A_CTRL, 32'h0);
  endtask

  task automatic t_stage_first;
    bus_write(A_CTRL, 32'h0);
    bus_write(A_STAGE, 32'd10);
    bus_write(A_CTRL, 32'h4);
    after_updates(1);
    rd_chk(A_COUNT, 32'd10, "R3 staged start");
    bus_write(A_STAGE, 32'd500);
    rd_chk(A_COUNT, 32'd10, "R3 no immediate effect");
    after_updates(2);
    rd_chk(A_COUNT, 32'd500, "R4 stage beats increment");
    after_updates(3);
    rd_chk(A_COUNT, 32'd501, "R4 increments afterwards");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_stage_defer();
    t_hold();
    t_alarm();
    t_mask();
    t_wrap();
    t_rollover();
    t_ignored();
    t_stage_first();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, got timeout expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule